// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer and Event Counter

A 16-bit up-counter that serves three uses through one set of registers. As an interval timer it counts a divided internal clock. The base clock is either the system clock divided by four or a tick from a slow oscillator, and a power-of-two prescaler divides it further. As an event counter it counts edges on an external pin after that pin has been synchronized. As a pulse-width meter it counts the divided internal clock only while the external pin sits between a start edge and a stop edge, then freezes the result until software acknowledges it.

When the counter rolls past full scale it reloads from a preload register and keeps running. At the same time it pulses an interrupt for one cycle, sets a sticky flag and toggles a divided-frequency output. That output can take over a shared pin in place of the ordinary I/O data. Software reaches every register through a plain byte-wide write strobe and a combinational read port, using a 3-bit address.

Top module: `evt_timer16`

## Requirements
- R1: After reset the control register reads 0x08 (edge-select bit 3 set, all other bits clear). The counter reads 0x0000, the status register reads 0x00, and irq is low.
- R2: Control register (address 0) bits 1 and 0 always read 0, whatever was written to them.
- R3: Control bits 7:6 select the mode: 00 none, 01 event, 10 timer, 11 pulse capture. In mode 00 the counter holds its value even when bit 4 is set.
- R4: Control bit 4 is the run enable. A write to address 0 that sets bit 4 while it was clear loads the counter from the preload register (address 2 low byte, address 3 high byte). While bit 4 is clear the counter holds its value.
- R5: In timer mode with control bit 5 = 0 and a prescale field of 0, the counter advances once every 4 clock cycles. The first step comes on the 4th rising edge after the enabling write edge.
- R6: With control bit 5 = 1 the count source is the lirc_tick input: one step for each cycle in which lirc_tick is high (prescale 0).
- R7: The prescale field (address 1, bits 2:0, value N) divides the selected source by 2^N. With N = 2 on the divided system clock, the counter advances once every 16 cycles.
- R8: In event mode the counter advances on each rising edge of ext_in when bit 3 = 0, and on each falling edge when bit 3 = 1. The edge is seen after a two-flop synchronizer.
- R9: In capture mode the counter loads the preload value on the start edge. It counts the divided internal clock until the stop edge. With bit 3 = 1 the start edge is rising and the stop edge is falling; with bit 3 = 0 the start edge is falling and the stop edge is rising.
- R10: Counting past 0xFFFF reloads the counter from preload, drives irq high for exactly one cycle and sets status bit 0 (address 6). Writing 1 to status bit 0 clears that flag.
- R11: The frequency output toggles on every overflow. pin_o carries that output when control bit 2 = 1 and carries io_dout when bit 2 = 0.
- R12: The capture stop edge sets status bit 1 and freezes the counter. Further pin edges have no effect until a write of 1 to status bit 1 clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 ctrl, 1 prescale, 2/3 preload, 4/5 count, 6 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| lirc_tick | input | 1 | One-cycle tick from the slow oscillator |
| ext_in | input | 1 | External event / pulse pin, asynchronous |
| io_dout | input | 1 | Ordinary I/O data for the shared pin |
| pin_o | output | 1 | Shared pin drive |
| irq | output | 1 | One-cycle overflow interrupt |

## Verification
The timer runs on each clock source and at two prescale settings. The exact cycle of a step tells apart a divide-by-4 base, the oscillator tick and a 2^N prescale. Event mode is driven with the same pulse train under both edge selections, which shows that exactly one edge per pulse is counted. Capture mode uses a high pulse and then a low pulse with known lengths. This separates start and stop polarity, and later pulses show that the frozen result ignores new edges. A preload just below full scale forces an overflow in a known cycle, which checks the reload, the single-cycle interrupt, the sticky flag and the pin takeover.

// File: rtl/evt_timer16.sv
module evt_timer16 #(
  parameter int SYS_DIV_W = 2,
  parameter int PSC_W     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       lirc_tick,
  input  logic       ext_in,
  input  logic       io_dout,
  output logic       pin_o,
  output logic       irq
);

  localparam int PRE_W = (1 << PSC_W) - 1;

  logic [7:2]       ctrl;
  logic [PSC_W-1:0] psc;
  logic [15:0]      preload, cnt;
  logic             ovf_flag, cap_done, cap_active, pfd_q, irq_q;
  logic [1:0]       ext_sync;
  logic             ext_prev;
  logic [SYS_DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;

  wire [1:0] mode     = ctrl[7:6];
  wire       src_lirc = ctrl[5];
  wire       run      = ctrl[4];
  wire       edge_sel = ctrl[3];
  wire       pfd_sel  = ctrl[2];

  wire wr_ctrl = wr_en && addr == 3'd0;
  wire wr_psc  = wr_en && addr == 3'd1;
  wire wr_plo  = wr_en && addr == 3'd2;
  wire wr_phi  = wr_en && addr == 3'd3;
  wire wr_stat = wr_en && addr == 3'd6;

  wire rise = ext_sync[1] & ~ext_prev;
  wire fall = ~ext_sync[1] & ext_prev;

  wire             sys_tick = &div_q;
  wire             src_tick = run && (src_lirc ? lirc_tick : sys_tick);
  wire [PRE_W:0]   one_hot  = (PRE_W+1)'(1) << psc;
  wire [PRE_W:0]   mask_w   = one_hot - (PRE_W+1)'(1);
  wire [PRE_W-1:0] pre_mask = mask_w[PRE_W-1:0];
  wire             pre_tick = src_tick && ((pre_q & pre_mask) == pre_mask);

  wire cap_mode   = run && mode == 2'b11;
  wire start_edge = cap_mode && !cap_active && !cap_done && (edge_sel ? rise : fall);
  wire stop_edge  = cap_mode && cap_active && (edge_sel ? fall : rise);

  wire inc_evt = run && mode == 2'b01 && (edge_sel ? fall : rise);
  wire inc_tmr = mode == 2'b10 && pre_tick;
  wire inc_cap = cap_mode && cap_active && pre_tick;
  wire inc     = inc_evt || inc_tmr || inc_cap;
  wire ovf     = inc && cnt == 16'hFFFF;
  wire load    = (wr_ctrl && wdata[4] && !run) || start_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= 6'b000010;
      psc     <= '0;
      preload <= '0;
    end else begin
      if (wr_ctrl) ctrl <= wdata[7:2];
      if (wr_psc)  psc  <= wdata[PSC_W-1:0];
      if (wr_plo)  preload[7:0]  <= wdata;
      if (wr_phi)  preload[15:8] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync <= '0;
      ext_prev <= 1'b0;
    end else begin
      ext_sync <= {ext_sync[0], ext_in};
      ext_prev <= ext_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (!run) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      if (src_tick) pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= preload;
    else if (inc)    cnt <= ovf ? preload : cnt + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_active <= 1'b0;
      cap_done   <= 1'b0;
    end else begin
      if (!cap_mode)       cap_active <= 1'b0;
      else if (start_edge) cap_active <= 1'b1;
      else if (stop_edge)  cap_active <= 1'b0;
      if (stop_edge)                cap_done <= 1'b1;
      else if (wr_stat && wdata[1]) cap_done <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      irq_q    <= 1'b0;
      pfd_q    <= 1'b0;
    end else begin
      irq_q <= ovf;
      pfd_q <= pfd_q ^ ovf;
      if (ovf)                      ovf_flag <= 1'b1;
      else if (wr_stat && wdata[0]) ovf_flag <= 1'b0;
    end
  end

  assign irq   = irq_q;
  assign pin_o = pfd_sel ? pfd_q : io_dout;

  always_comb begin
    case (addr)
      3'd0:    rdata = {ctrl, 2'b00};
      3'd1:    rdata = 8'(psc);
      3'd2:    rdata = preload[7:0];
      3'd3:    rdata = preload[15:8];
      3'd4:    rdata = cnt[7:0];
      3'd5:    rdata = cnt[15:8];
      3'd6:    rdata = {6'b0, cap_done, ovf_flag};
      default: rdata = 8'h00;
    endcase
  end

  assert_idle_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7:6] == 2'b00 && !wr_en) |=> $stable(cnt));

  assert_stopped_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[4] && !wr_en) |=> $stable(cnt));

  assert_irq_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);

  assert_pfd_only_on_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(pfd_q));

  assert_capture_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && ctrl[7:6] == 2'b11 && !wr_en) |=> $stable(cnt));

  assert_done_from_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_done) |-> $past(ctrl[7:6]) == 2'b11);

  always_comb begin
    if (rst_n && addr == 3'd0) assert_low_bits_zero_R2: assert (rdata[1:0] == 2'b00);
  end

endmodule

// File: tb/evt_timer16_tb_top.sv
`timescale 1ns/1ps
module evt_timer16_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, lirc_tick = 0, ext_in = 0, io_dout = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic pin_o, irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_timer16 dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lirc_tick(lirc_tick), .ext_in(ext_in), .io_dout(io_dout),
    .pin_o(pin_o), .irq(irq));

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #0.2; d = rdata;
  endtask

  task automatic rd_cnt(output int v);
    logic [7:0] lo, hi;
    rd(3'd4, lo); rd(3'd5, hi);
    v = {hi, lo};
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] pre, input logic [2:0] ps);
    wr(0, 8'h08); wr(6, 8'h03);
    wr(1, {5'b0, ps}); wr(2, pre[7:0]); wr(3, pre[15:8]);
  endtask

  task automatic pulse_ext(input int hi, input int lo);
    @(negedge clk); ext_in = 1; wait_cyc(hi); ext_in = 0; wait_cyc(lo);
  endtask

  task automatic t_reset;
    logic [7:0] d; int v;
    rd(0, d); chk("R1 ctrl", d, 8'h08);
    rd_cnt(v); chk("R1 count", v, 0);
    rd(6, d); chk("R1 status", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_lowbits;
    logic [7:0] d;
    wr(0, 8'h0B); rd(0, d); chk("R2 low bits", d, 8'h08);
  endtask

  task automatic t_idle_mode;
    int v;
    setup(16'h0042, 0); wr(0, 8'h18); wait_cyc(40);
    rd_cnt(v); chk("R3 idle mode", v, 16'h0042);
  endtask

  task automatic t_timer_sys;
    int v;
    setup(16'h0000, 0); wr(0, 8'h98);
    wait_cyc(3); rd_cnt(v); chk("R5 before 4th edge", v, 0);
    wait_cyc(1); rd_cnt(v); chk("R5 4th edge", v, 1);
    wait_cyc(16); rd_cnt(v); chk("R5 after 20", v, 5);
    wr(0, 8'h88); rd_cnt(v); chk("R4 stop value", v, 5);
    wait_cyc(20); rd_cnt(v); chk("R4 held while stopped", v, 5);
  endtask

  task automatic t_lirc;
    int v;
    setup(16'h1234, 0); wr(0, 8'hB8); wait_cyc(30);
    rd_cnt(v); chk("R4 load on enable", v, 16'h1234);
    repeat (5) begin
      @(negedge clk); lirc_tick = 1; @(negedge clk); lirc_tick = 0; wait_cyc(2);
    end
    rd_cnt(v); chk("R6 lirc ticks", v, 16'h1239);
  endtask

  task automatic t_prescale;
    int v;
    setup(16'h0000, 3'd2); wr(0, 8'h98);
    wait_cyc(63); rd_cnt(v); chk("R7 div16 edge 63", v, 3);
    wait_cyc(1); rd_cnt(v); chk("R7 div16 edge 64", v, 4);
  endtask

  task automatic t_event;
    int v;
    setup(16'h0000, 0); wr(0, 8'h50);
    repeat (3) pulse_ext(4, 4);
    wait_cyc(6); rd_cnt(v); chk("R8 rising count", v, 3);
    wr(0, 8'h08); wr(0, 8'h58);
    pulse_ext(4, 4); pulse_ext(4, 4);
    wait_cyc(6); rd_cnt(v); chk("R8 falling count", v, 2);
  endtask

  task automatic t_capture;
    int v; logic [7:0] d;
    setup(16'h0000, 0); wr(0, 8'hD8);
    pulse_ext(40, 8);
    rd_cnt(v); chk("R9 high pulse width", v, 10);
    rd(6, d); chk("R12 done flag", d[1], 1);
    pulse_ext(12, 8); wait_cyc(10);
    rd_cnt(v); chk("R12 frozen", v, 10);
    wr(6, 8'h02); rd(6, d); chk("R12 done cleared", d[1], 0);
    wr(0, 8'hD0);
    @(negedge clk); ext_in = 1; wait_cyc(8);
    ext_in = 0; wait_cyc(20); ext_in = 1; wait_cyc(8);
    rd_cnt(v); chk("R9 low pulse width", v, 5);
    ext_in = 0; wait_cyc(6);
  endtask

  task automatic t_overflow;
    int v; logic [7:0] d;
    setup(16'hFFFE, 0); io_dout = 0; wr(0, 8'h9C);
    wait_cyc(7); chk("R10 irq before", irq, 0);
    wait_cyc(1);
    chk("R10 irq pulse", irq, 1);
    rd_cnt(v); chk("R10 reload", v, 16'hFFFE);
    chk("R11 pfd on pin", pin_o, 1);
    wait_cyc(1); chk("R10 irq one cycle", irq, 0);
    wr(0, 8'h0C); rd(6, d); chk("R10 sticky flag", d[0], 1);
    wr(6, 8'h01); rd(6, d); chk("R10 flag cleared", d[0], 0);
    wr(0, 8'h08); io_dout = 1; #0.2; chk("R11 io on pin", pin_o, 1);
    io_dout = 0; #0.2; chk("R11 io on pin low", pin_o, 0);
  endtask

  initial begin
    wait_cyc(3); rst_n = 1; wait_cyc(2);
    t_reset(); t_lowbits(); t_idle_mode(); t_timer_sys(); t_lirc();
    t_prescale(); t_event(); t_capture(); t_overflow();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule